// File: doc/BRIEF.md
# Three-Channel Reloadable Down-Counter Timer

This block is a memory-mapped timer with three 32-bit channels that run independently. Each channel has a down-counter, a reload value and a control word. One start register holds a run bit for each channel. While its run bit is set, a channel decrements once per tick. The tick comes from one of five taps of a shared free-running prescaler, from a real-time-clock strobe, or from an external strobe. When a tick arrives with the counter at zero, the channel loads the reload value, sets its underflow flag and, if enabled, raises its interrupt line.

Software reaches every register over a simple single-cycle bus. A write takes effect at the clock edge on which `bus_wr_en` is high. Read data is combinational from the address. The prescaler is a single counter shared by all channels. Each channel receives its tick as a one-cycle strobe, so all counting stays synchronous to `clk`.

Top module: `tmr3_top`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `src_err` are 0.
- R2: Bit n of the start register (address 0x00, bits [2:0]) runs channel n. A stopped channel holds its count. Bits above 2 read 0.
- R3: Channel n has its control word at byte address 0x04+12n, its reload value at 0x08+12n and its count at 0x0C+12n. Reads of any other address return 0, and writes to any other address change nothing.
- R4: Control bits [2:0] pick the tick. Codes 0 to 4 give one tick every 4, 16, 64, 256 and 1024 clocks. Code 6 uses `rtc_tick` and code 7 uses `ext_tick`; each cycle a strobe is high counts as one tick.
- R5: Code 5 gives one tick every 4096 clocks and holds `src_err[n]` high for as long as the code is selected.
- R6: From a count of N, N ticks bring the count to 0. Tick N+1 loads the reload value and sets the underflow flag at control bit 8.
- R7: A control write stores bits [15:0] as written, except bit 8. Bit 8 becomes its old value ANDed with the written bit, so software can clear it but never set it. Bits [31:16] read 0.
- R8: `irq[n]` is high exactly when control bit 8 and the enable at control bit 5 are both 1. It rises or falls with whichever of the two changes.
- R9: The count may be written at any time, including while running. In a cycle where a write and a tick coincide, the written value is kept, and counting continues from it.
- R10: An underflow in the same cycle as a control write that clears bit 8 leaves bit 8 set.
- R11: Ticks, flags and counts of one channel do not affect the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rtc_tick | input | 1 | Real-time-clock tick strobe (code 6) |
| ext_tick | input | 1 | External tick strobe (code 7) |
| irq | output | 3 | Per-channel interrupt |
| src_err | output | 3 | Per-channel illegal tick-source indication |

## Verification
A software write and a tick can land on the same clock edge. A count write can meet a decrement, and a control write that clears the flag can meet an underflow. The bench provokes both by raising `ext_tick` on the same cycle as the bus write. It then judges the result by reading back the count (the written value must win) and the control word (the flag must stay set, and the reload must have happened). The prescaler taps are checked by polling a running count every cycle and measuring the spacing between changes.

// File: rtl/tmr3_pkg.sv
`timescale 1ns/1ps
package tmr3_pkg;
    localparam int BUS_W    = 32;
    localparam int CNT_W    = 32;
    localparam int CTL_W    = 16;
    localparam int SRC_W    = 3;
    localparam int NTAP     = 6;      // taps /4 .. /4096, two bits apart
    localparam int UNF_BIT  = 8;
    localparam int UNIE_BIT = 5;

    localparam logic [SRC_W-1:0] SRC_BAD = 3'd5;
    localparam logic [SRC_W-1:0] SRC_RTC = 3'd6;
    localparam logic [SRC_W-1:0] SRC_EXT = 3'd7;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [CTL_W-1:0] ctl;
    } chan_st_t;
endpackage

// File: rtl/tmr3_prescale.sv
`timescale 1ns/1ps
module tmr3_prescale
    import tmr3_pkg::*;
#(
    parameter int TAPS = NTAP
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tap_stb
);
    localparam int PW = 2 * TAPS;

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // tap i strobes once every 2^(2i+2) clocks
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_stb[i] = &div_q[2*i+1:0];

        AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            tap_stb[i] |=> !tap_stb[i]); // R4
    end
endmodule

// File: rtl/tmr3_chan.sv
`timescale 1ns/1ps
module tmr3_chan
    import tmr3_pkg::*;
#(
    parameter int TAPS = NTAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TAPS-1:0]  tap_stb,
    input  logic             rtc_stb,
    input  logic             ext_stb,
    input  logic             wr_ctl,
    input  logic             wr_rld,
    input  logic             wr_cnt,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rld,
    output logic [CTL_W-1:0] ctl,
    output logic             irq,
    output logic             src_err
);
    chan_st_t         st_d, st_q;
    logic [SRC_W-1:0] src;
    logic             tick, step, uf;

    always_comb begin
        st_d = st_q;
        src  = st_q.ctl[SRC_W-1:0];

        tick = 1'b0;
        if (src == SRC_RTC)      tick = rtc_stb;
        else if (src == SRC_EXT) tick = ext_stb;
        else begin
            for (int t = 0; t < TAPS; t++) begin
                if (src == SRC_W'(t)) tick = tap_stb[t];
            end
        end

        step = run & tick;
        uf   = step & (st_q.cnt == '0);

        // count: software write wins over a tick in the same cycle
        if (wr_cnt)     st_d.cnt = wdata[CNT_W-1:0];
        else if (uf)    st_d.cnt = st_q.rld;
        else if (step)  st_d.cnt = st_q.cnt - 1'b1;

        if (wr_rld)     st_d.rld = wdata[CNT_W-1:0];

        if (wr_ctl) begin
            st_d.ctl          = wdata[CTL_W-1:0];
            st_d.ctl[UNF_BIT] = st_q.ctl[UNF_BIT] & wdata[UNF_BIT];
        end
        // hardware set beats a software clear
        if (uf)         st_d.ctl[UNF_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign rld     = st_q.rld;
    assign ctl     = st_q.ctl;
    assign irq     = st_q.ctl[UNF_BIT] & st_q.ctl[UNIE_BIT];
    assign src_err = (src == SRC_BAD);

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !st_q.ctl[UNF_BIT] && !uf) |=> !st_q.ctl[UNF_BIT]); // R7

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && st_q.cnt == '0 && !wr_cnt)
            |=> (st_q.cnt == $past(st_q.rld)) && st_q.ctl[UNF_BIT]); // R6

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && st_q.cnt != '0 && !wr_cnt)
            |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R6

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(st_q.cnt)); // R2

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> st_q.cnt == $past(wdata[CNT_W-1:0])); // R9
endmodule

// File: rtl/tmr3_top.sv
`timescale 1ns/1ps
module tmr3_top
    import tmr3_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_en,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rtc_tick,
    input  logic             ext_tick,
    output logic [NCH-1:0]   irq,
    output logic [NCH-1:0]   src_err
);
    localparam int STRIDE   = 12;
    localparam int OFS_CTL  = 4;
    localparam int OFS_RLD  = 8;
    localparam int OFS_CNT  = 12;
    localparam logic [AW-1:0] A_START = '0;

    logic [NCH-1:0]  run_d, run_q;
    logic [NTAP-1:0] tap_stb;
    logic [NCH-1:0]  wr_ctl, wr_rld, wr_cnt;
    logic [CNT_W-1:0] cnt_w [NCH];
    logic [CNT_W-1:0] rld_w [NCH];
    logic [CTL_W-1:0] ctl_w [NCH];

    tmr3_prescale #(.TAPS(NTAP)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_stb (tap_stb)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [AW-1:0] A_CTL = AW'(OFS_CTL + STRIDE * n);
        localparam logic [AW-1:0] A_RLD = AW'(OFS_RLD + STRIDE * n);
        localparam logic [AW-1:0] A_CNT = AW'(OFS_CNT + STRIDE * n);

        assign wr_ctl[n] = bus_wr_en && (bus_addr == A_CTL);
        assign wr_rld[n] = bus_wr_en && (bus_addr == A_RLD);
        assign wr_cnt[n] = bus_wr_en && (bus_addr == A_CNT);

        tmr3_chan #(.TAPS(NTAP)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q[n]),
            .tap_stb (tap_stb),
            .rtc_stb (rtc_tick),
            .ext_stb (ext_tick),
            .wr_ctl  (wr_ctl[n]),
            .wr_rld  (wr_rld[n]),
            .wr_cnt  (wr_cnt[n]),
            .wdata   (bus_wdata),
            .cnt     (cnt_w[n]),
            .rld     (rld_w[n]),
            .ctl     (ctl_w[n]),
            .irq     (irq[n]),
            .src_err (src_err[n])
        );
    end

    always_comb begin
        run_d = run_q;
        if (bus_wr_en && bus_addr == A_START) run_d = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_START) bus_rdata[NCH-1:0] = run_q;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == AW'(OFS_CTL + STRIDE * n)) bus_rdata[CTL_W-1:0] = ctl_w[n];
            if (bus_addr == AW'(OFS_RLD + STRIDE * n)) bus_rdata[CNT_W-1:0] = rld_w[n];
            if (bus_addr == AW'(OFS_CNT + STRIDE * n)) bus_rdata[CNT_W-1:0] = cnt_w[n];
        end
    end

    AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_START) |=> run_q == $past(bus_wdata[NCH-1:0])); // R2

    AST_RUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_addr == A_START) |=> $stable(run_q)); // R3
endmodule

// File: tb/tmr3_top_tb_top.sv
`timescale 1ns/1ps
module tmr3_top_tb_top;
    localparam int NV = 48;
    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_ET = 3'd2, K_RT = 3'd3, K_IQ = 3'd4;

    // {kind, addr, data, expected}
    localparam logic [74:0] VEC [NV] = '{
        {K_WR, 8'h04, 32'h27,       32'h0},   // 0  ch0 ext src + irq enable
        {K_RD, 8'h04, 32'h0,        32'h27},  // 1  R7
        {K_WR, 8'h08, 32'h5,        32'h0},
        {K_WR, 8'h0C, 32'h2,        32'h0},
        {K_WR, 8'h00, 32'h1,        32'h0},   // 4  run ch0
        {K_ET, 8'h00, 32'd2,        32'h0},
        {K_RD, 8'h0C, 32'h0,        32'h0},   // 6  R6 reaches zero
        {K_IQ, 8'h00, 32'h0,        32'h0},
        {K_ET, 8'h00, 32'd1,        32'h0},
        {K_RD, 8'h0C, 32'h0,        32'h5},   // 9  R6 reload
        {K_RD, 8'h04, 32'h0,        32'h127}, // 10 R6 flag
        {K_IQ, 8'h00, 32'h0,        32'h1},   // 11 R8
        {K_WR, 8'h04, 32'h107,      32'h0},
        {K_RD, 8'h04, 32'h0,        32'h107},
        {K_IQ, 8'h00, 32'h0,        32'h0},   // 14 R8 enable dropped
        {K_WR, 8'h04, 32'h127,      32'h0},
        {K_IQ, 8'h00, 32'h0,        32'h1},   // 16 R8 enable raised
        {K_WR, 8'h04, 32'h27,       32'h0},
        {K_RD, 8'h04, 32'h0,        32'h27},  // 18 R7 cleared
        {K_IQ, 8'h00, 32'h0,        32'h0},
        {K_WR, 8'h04, 32'h127,      32'h0},
        {K_RD, 8'h04, 32'h0,        32'h27},  // 21 R7 no software set
        {K_WR, 8'h04, 32'hFFFFFF27, 32'h0},
        {K_RD, 8'h04, 32'h0,        32'hFE27},// 23 R7 field storage
        {K_WR, 8'h04, 32'h27,       32'h0},
        {K_WR, 8'h00, 32'h0,        32'h0},   // 25 stop
        {K_ET, 8'h00, 32'd3,        32'h0},
        {K_RD, 8'h0C, 32'h0,        32'h5},   // 27 R2 holds
        {K_WR, 8'h0C, 32'h10,       32'h0},
        {K_RD, 8'h0C, 32'h0,        32'h10},  // 29 R9
        {K_WR, 8'h10, 32'h26,       32'h0},   // ch1 rtc src
        {K_WR, 8'h14, 32'h7,        32'h0},
        {K_WR, 8'h18, 32'h1,        32'h0},
        {K_WR, 8'h00, 32'h2,        32'h0},
        {K_RT, 8'h00, 32'd1,        32'h0},
        {K_RD, 8'h18, 32'h0,        32'h0},   // 35 R4 rtc
        {K_ET, 8'h00, 32'd1,        32'h0},
        {K_RD, 8'h18, 32'h0,        32'h0},   // 37 R4 ext ignored by rtc channel
        {K_RT, 8'h00, 32'd1,        32'h0},
        {K_RD, 8'h18, 32'h0,        32'h7},   // 39 R6
        {K_IQ, 8'h00, 32'h0,        32'h2},   // 40 R11
        {K_RD, 8'h0C, 32'h0,        32'h10},  // 41 R11
        {K_RD, 8'h28, 32'h0,        32'h0},   // 42 R3
        {K_WR, 8'h28, 32'hDEAD,     32'h0},
        {K_RD, 8'h00, 32'h0,        32'h2},   // 44 R3
        {K_RD, 8'h3C, 32'h0,        32'h0},   // 45 R3
        {K_WR, 8'h00, 32'hFFFFFFF8, 32'h0},
        {K_RD, 8'h00, 32'h0,        32'h0}    // 47 R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rtc_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [2:0]  irq;
    logic [2:0]  src_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tmr3_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rtc_tick  (rtc_tick),
        .ext_tick  (ext_tick),
        .irq       (irq),
        .src_err   (src_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
        end
    endtask

    task automatic pulse_rtc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rtc_tick = 1'b1;
            @(negedge clk); rtc_tick = 1'b0;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, prev;
        int          cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 40; a += 4) begin
            rd(6'(a), r);
            check("R1", r, 32'h0);
        end
        #0 check("R1 irq", {29'b0, irq}, 32'h0);
        check("R1 src_err", {29'b0, src_err}, 32'h0);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  k;
            logic [5:0]  a;
            logic [31:0] d, e;
            k = VEC[v][74:72]; a = VEC[v][69:64]; d = VEC[v][63:32]; e = VEC[v][31:0];
            case (k)
                K_WR: wr(a, d);
                K_RD: begin rd(a, r); check($sformatf("vec %0d R3/R6/R7", v), r, e); end
                K_ET: pulse_ext(int'(d));
                K_RT: pulse_rtc(int'(d));
                default: begin
                    @(negedge clk); #1;
                    check($sformatf("vec %0d R8/R11 irq", v), {29'b0, irq}, e);
                end
            endcase
        end

        // R9: count write and tick on the same edge, ch2 on ext source
        wr(6'h1C, 32'h07);
        wr(6'h20, 32'h9);
        wr(6'h24, 32'h3);
        wr(6'h00, 32'h4);
        @(negedge clk);
        bus_addr = 6'h24; bus_wdata = 32'h40; bus_wr_en = 1'b1; ext_tick = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; ext_tick = 1'b0;
        rd(6'h24, r); check("R9 write wins", r, 32'h40);
        pulse_ext(1);
        rd(6'h24, r); check("R9 continues", r, 32'h3F);

        // R10: underflow and flag-clearing control write on the same edge
        wr(6'h24, 32'h0);
        @(negedge clk);
        bus_addr = 6'h1C; bus_wdata = 32'h07; bus_wr_en = 1'b1; ext_tick = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; ext_tick = 1'b0;
        rd(6'h1C, r); check("R10 flag kept", r, 32'h107);
        rd(6'h24, r); check("R10 reload", r, 32'h9);
        wr(6'h00, 32'h0);

        // R4/R5: prescaler tap spacing, ch0
        for (int c = 0; c < 6; c++) begin
            wr(6'h04, 32'(c));
            wr(6'h0C, 32'hFFFF);
            wr(6'h00, 32'h1);
            #1 check($sformatf("R5 src_err code %0d", c), {29'b0, src_err},
                     (c == 5) ? 32'h1 : 32'h0);
            rd(6'h0C, prev);
            cyc = 0;
            do begin rd(6'h0C, r); cyc++; end while (r == prev && cyc < 10000);
            prev = r;
            cyc = 0;
            do begin rd(6'h0C, r); cyc++; end while (r == prev && cyc < 10000);
            check($sformatf("R4 period code %0d", c), 32'(cyc), 32'(4 << (2 * c)));
            wr(6'h00, 32'h0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule